// File: doc/BRIEF.md
# Configuration Request Type Converter with Private Device Redirect

This block sits on the downstream side of a bus bridge. It turns a captured Type 1 configuration address into the Type 0 address that the bridge drives on its secondary bus. The Type 1 device number becomes a single asserted IDSEL line in the upper half of the address. The function and register fields are carried straight across, and the low two bits are forced to the Type 0 code.

A small set of device numbers can be made private. Each one has a mask bit that is loaded from board straps while reset is held. When a request targets a masked device, it is steered to the reserved slot, device 15, whose IDSEL is address bit 31. The request does not reach the device's own line. Secondary buses that use masking should leave device 15 unpopulated. Device numbers 16 to 31 have no IDSEL line, so no device claims those requests.

The output is registered with a latency of one clock. When no request is presented, the last converted address is held.

Top module: `cfg_type_convert`

## Requirements
- R1: While `rst` is high at a rising clock edge, `t0_valid` and `t0_addr` are cleared to zero.
- R2: `t0_valid` is high exactly in the cycle after a cycle in which `req_valid` was high.
- R3: For an unmasked device number N from 0 to 15 (`req_addr[15:11]`), the output `t0_addr[31:16]` has only bit 16+N set.
- R4: For device numbers 16 to 31, `t0_addr[31:16]` is all zero.
- R5: For a masked device, `t0_addr[31:16]` has only bit 31 set, and the device's own bit is clear.
- R6: The mask straps map to devices as follows: `strap_mask[0]`→1, `[1]`→4, `[2]`→5, `[3]`→6, `[4]`→7, `[5]`→9, `[6]`→13. No other device number can be masked.
- R7: The function field `req_addr[10:8]` appears on `t0_addr[10:8]` and the register field `req_addr[7:2]` appears on `t0_addr[7:2]`. Bits `t0_addr[15:11]` and `t0_addr[1:0]` are zero.
- R8: The mask is the value of `strap_mask` at the last rising edge with `rst` high. Later changes of `strap_mask` have no effect.
- R9: While `req_valid` is low, `t0_addr` keeps its previous value.
- R10: The bus number `req_addr[23:16]`, the bits `req_addr[31:24]` and the bits `req_addr[1:0]` have no effect on `t0_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the straps are captured while it is high |
| strap_mask | input | 7 | Private device mask straps (mapping in R6) |
| req_valid | input | 1 | A Type 1 address is presented this cycle |
| req_addr | input | 32 | Type 1 address: bus 23:16, device 15:11, function 10:8, register 7:2 |
| t0_valid | output | 1 | Converted Type 0 address is valid |
| t0_addr | output | 32 | Type 0 address: IDSEL 31:16, function 10:8, register 7:2 |

## Verification
Several properties are checked on every cycle:
- the one-cycle valid timing;
- that at most one IDSEL bit is set;
- that the unused address bits are zero;
- that a redirected request lands on bit 31 only;
- that requests to devices above 15 assert no IDSEL;
- that the address holds while idle;
- that the mask register stays fixed once reset is released.

The bench scenarios are needed for the rest. They show which strap bit belongs to which device, that only the named devices can be masked, that the correct single line is chosen for each unmasked device, and that strap changes after reset and the ignored address fields do not change the result.

// File: rtl/cfgconv_pkg.sv
package cfgconv_pkg;

    localparam int ADDR_W  = 32;
    localparam int BUS_W   = 8;
    localparam int DEV_W   = 5;
    localparam int FUNC_W  = 3;
    localparam int REG_W   = 6;
    localparam int KIND_W  = 2;
    localparam int IDSEL_W = 16;
    localparam int MASK_W  = 7;
    localparam int RSVD_W  = ADDR_W - BUS_W - DEV_W - FUNC_W - REG_W - KIND_W;
    localparam int GAP_W   = ADDR_W - IDSEL_W - FUNC_W - REG_W - KIND_W;
    localparam int RESV_DEV = IDSEL_W - 1;

    localparam logic [KIND_W-1:0] KIND_TYPE0 = 2'b00;

    typedef struct packed {
        logic [RSVD_W-1:0] rsvd;
        logic [BUS_W-1:0]  bus;
        logic [DEV_W-1:0]  dev;
        logic [FUNC_W-1:0] func;
        logic [REG_W-1:0]  regn;
        logic [KIND_W-1:0] kind;
    } t1_addr_t;

    typedef struct packed {
        logic [IDSEL_W-1:0] idsel;
        logic [GAP_W-1:0]   gap;
        logic [FUNC_W-1:0]  func;
        logic [REG_W-1:0]   regn;
        logic [KIND_W-1:0]  kind;
    } t0_addr_t;

    // Device number governed by each mask bit.
    function automatic int mask_dev(input int k);
        case (k)
            0:       return 1;
            1:       return 4;
            2:       return 5;
            3:       return 6;
            4:       return 7;
            5:       return 9;
            6:       return 13;
            default: return -1;
        endcase
    endfunction

    function automatic logic dev_is_masked(input logic [DEV_W-1:0] dev,
                                           input logic [MASK_W-1:0] mask);
        logic hit;
        hit = 1'b0;
        for (int k = 0; k < MASK_W; k++) begin
            if (mask[k] && (int'(dev) == mask_dev(k))) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/cfgconv_strap_reg.sv
module cfgconv_strap_reg
    import cfgconv_pkg::*;
#(
    parameter int W = MASK_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] strap_i,
    output logic [W-1:0] mask_o
);

    logic [W-1:0] mask_q;

    // Follows the straps while reset is held; frozen afterwards.
    always_ff @(posedge clk) begin
        if (rst) mask_q <= strap_i;
    end

    assign mask_o = mask_q;

    p_mask_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mask_q))
        else $error("mask changed after reset release");

endmodule

// File: rtl/cfgconv_idsel_dec.sv
module cfgconv_idsel_dec
    import cfgconv_pkg::*;
#(
    parameter int DW = DEV_W,
    parameter int SW = IDSEL_W,
    parameter int MW = MASK_W
) (
    input  logic [DW-1:0] dev_i,
    input  logic [MW-1:0] mask_i,
    output logic [SW-1:0] idsel_o,
    output logic          redirect_o
);

    localparam int RESV = SW - 1;

    logic [SW-1:0] hit;
    logic          redirect;

    assign redirect   = dev_is_masked(dev_i, mask_i);
    assign redirect_o = redirect;

    for (genvar n = 0; n < SW; n++) begin : g_sel
        assign hit[n] = (dev_i == DW'(n));
        if (n == RESV) begin : g_resv
            assign idsel_o[n] = hit[n] | redirect;
        end else begin : g_norm
            assign idsel_o[n] = hit[n] & ~redirect;
        end
    end

endmodule

// File: rtl/cfg_type_convert.sv
module cfg_type_convert
    import cfgconv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MASK_W-1:0] strap_mask,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              t0_valid,
    output logic [ADDR_W-1:0] t0_addr
);

    t1_addr_t           t1;
    t0_addr_t           nxt;
    t0_addr_t           addr_q;
    logic               valid_q;
    logic [MASK_W-1:0]  mask;
    logic [IDSEL_W-1:0] idsel;
    logic               redirect;

    assign t1 = t1_addr_t'(req_addr);

    cfgconv_strap_reg #(.W(MASK_W)) u_strap (
        .clk     (clk),
        .rst     (rst),
        .strap_i (strap_mask),
        .mask_o  (mask)
    );

    cfgconv_idsel_dec #(.DW(DEV_W), .SW(IDSEL_W), .MW(MASK_W)) u_dec (
        .dev_i      (t1.dev),
        .mask_i     (mask),
        .idsel_o    (idsel),
        .redirect_o (redirect)
    );

    always_comb begin
        nxt       = '0;
        nxt.idsel = idsel;
        nxt.func  = t1.func;
        nxt.regn  = t1.regn;
        nxt.kind  = KIND_TYPE0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
        end else begin
            valid_q <= req_valid;
            if (req_valid) addr_q <= nxt;
        end
    end

    assign t0_valid = valid_q;
    assign t0_addr  = addr_q;

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> t0_valid)
        else $error("valid not propagated");

    p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !t0_valid)
        else $error("spurious valid");

    p_idsel_single_r3: assert property (@(posedge clk) disable iff (rst)
        t0_valid |-> $onehot0(t0_addr[ADDR_W-1 -: IDSEL_W]))
        else $error("more than one IDSEL line");

    p_high_dev_none_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[15]) |=> (t0_addr[ADDR_W-1 -: IDSEL_W] == '0))
        else $error("IDSEL driven for device above 15");

    p_redirect_resv_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && redirect) |=>
            (t0_addr[ADDR_W-1] && (t0_addr[ADDR_W-2 -: IDSEL_W-1] == '0)))
        else $error("masked device not sent to reserved slot");

    p_fixed_bits_r7: assert property (@(posedge clk) disable iff (rst)
        t0_valid |-> ((t0_addr[15:11] == '0) && (t0_addr[1:0] == '0)))
        else $error("reserved address bits set");

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(t0_addr))
        else $error("address changed while idle");

endmodule

// File: tb/sim_cfg_type_convert.sv
module sim_cfg_type_convert;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  strap_mask = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        t0_valid;
    logic [31:0] t0_addr;

    int checks = 0;
    int fails  = 0;
    logic [6:0]  cur_mask;
    logic [31:0] last_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_type_convert u0 (
        .clk        (clk),
        .rst        (rst),
        .strap_mask (strap_mask),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .t0_valid   (t0_valid),
        .t0_addr    (t0_addr)
    );

    function automatic int tb_mdev(input int k);
        int tbl[7] = '{1, 4, 5, 6, 7, 9, 13};
        return tbl[k];
    endfunction

    function automatic logic tb_masked(input int dev, input logic [6:0] m);
        for (int k = 0; k < 7; k++) if (m[k] && dev == tb_mdev(k)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] tb_expect(input logic [31:0] a, input logic [6:0] m);
        int dev;
        logic [15:0] sel;
        dev = int'(a[15:11]);
        if (dev >= 16)              sel = 16'h0;
        else if (tb_masked(dev, m)) sel = 16'h8000;
        else                        sel = 16'(1) << dev;
        return {sel, 5'b0, a[10:8], a[7:2], 2'b00};
    endfunction

    function automatic string tb_tag(input logic [31:0] a, input logic [6:0] m);
        int dev;
        dev = int'(a[15:11]);
        if (dev >= 16) return "R4";
        if (tb_masked(dev, m)) return "R5";
        return "R3";
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_reset(input logic [6:0] m);
        @(negedge clk);
        rst = 1'b1;
        strap_mask = m;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 valid", {31'b0, t0_valid}, 32'h0);
        chk("R1 addr", t0_addr, 32'h0);
        rst = 1'b0;
        cur_mask = m;
        last_exp = 32'h0;
    endtask

    // Drive at a falling edge, sample at the following falling edge.
    task automatic req(input logic [31:0] a, input string tag);
        req_valid = 1'b1;
        req_addr = a;
        last_exp = tb_expect(a, cur_mask);
        @(negedge clk);
        chk({tag, " R2 valid"}, {31'b0, t0_valid}, 32'h1);
        chk({tag, " R7 addr"}, t0_addr, last_exp);
    endtask

    task automatic idle(input logic [31:0] a);
        req_valid = 1'b0;
        req_addr = a;
        @(negedge clk);
        chk("R2 idle valid", {31'b0, t0_valid}, 32'h0);
        chk("R9 hold", t0_addr, last_exp);
    endtask

    function automatic logic [31:0] mk(input int dev, input int fn, input int rg);
        return {8'h00, 8'h00, 5'(dev), 3'(fn), 6'(rg), 2'b01};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        logic [6:0] phase_masks[4];
        void'($urandom(32'd7321));
        phase_masks[0] = 7'h00;
        phase_masks[1] = 7'h7F;
        phase_masks[2] = 7'h2A;
        phase_masks[3] = 7'($urandom);

        foreach (phase_masks[p]) begin
            do_reset(phase_masks[p]);
            for (int d = 0; d < 32; d++) begin
                logic [31:0] a;
                a = mk(d, d % 8, (d * 5) % 64);
                req(a, tb_tag(a, cur_mask));
            end
            idle(32'hFFFF_FFFF);
            for (int i = 0; i < 60; i++) begin
                logic [31:0] a;
                a = $urandom;
                if ($urandom % 4 == 0) idle(a);
                else req(a, tb_tag(a, cur_mask));
            end
        end

        // R6: each strap bit alone redirects only its own device.
        for (int k = 0; k < 7; k++) begin
            do_reset(7'(1) << k);
            for (int d = 0; d < 16; d++) begin
                req(mk(d, 3, 17), (d == tb_mdev(k)) ? "R6 mapped" : "R6 other");
            end
        end

        // R8: straps changed after reset have no effect.
        do_reset(7'h00);
        strap_mask = 7'h7F;
        for (int k = 0; k < 7; k++) req(mk(tb_mdev(k), 1, 2), "R8 late strap");
        do_reset(7'h7F);
        strap_mask = 7'h00;
        for (int k = 0; k < 7; k++) req(mk(tb_mdev(k), 6, 40), "R8 late strap");

        // R10: bus number and ignored bits do not change the result.
        do_reset(7'h05);
        for (int i = 0; i < 20; i++) begin
            logic [31:0] a;
            a = $urandom;
            req({a[31:16], 5'd5, a[10:0]}, "R10 noise");
            chk("R10 fixed", t0_addr, tb_expect({16'h0, 5'd5, a[10:2], 2'b00}, cur_mask));
        end
        idle(32'h1234_5678);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule